// File: doc/BRIEF.md
# Two-Field Encoded SCL Clock Prescaler

This block derives the clock of a two-wire serial bus master from a much faster system clock. A configuration byte carries two small codes. One picks a fine factor from a short non-linear set. The other picks a coarse factor from a second set. The SCL period, counted in system clocks, is the product of the two factors. Every such product is even, so the high and low halves of SCL are each exactly half the period.

Two cascaded counters do the division. The fine counter issues a tick once every fine-factor clocks. The coarse counter counts ticks and toggles SCL after half the coarse factor's ticks. A configuration write goes into a holding register at once. The dividers pick it up only at the next SCL falling edge, or straight away while the block is disabled, so a running clock never shows a short phase.

A bit engine uses the two one-cycle strobes to find the exact cycle in which SCL rises or falls. Clearing the enable parks SCL high and clears both counters.

Top module: `scl_prescaler`

## Requirements
- R1: After synchronous reset the configuration reads 0x00, scl_o is high and neither strobe is active. The default setting gives an SCL period of 32 system clocks.
- R2: The fine code sits in configuration bits [2:0]. Codes 000 to 011 give factor 2, 100 gives 3, 101 gives 4, 110 gives 5 and 111 gives 8.
- R3: The coarse code sits in configuration bits [4:3]. Code 00 gives factor 16, 01 gives 32, 10 gives 128 and 11 gives 1024.
- R4: While enabled, SCL repeats with a period of fine factor times coarse factor system clocks, with equal high and low halves. For example, value 0x0D gives 128 clocks and 0x15 gives 512.
- R5: cfg_rdata returns bits [4:0] of the last value written, and bits [7:5] always read as zero.
- R6: A configuration written while the block is enabled leaves the SCL period in progress unchanged. The new factors apply from the next falling edge of SCL.
- R7: While en is low, scl_o is high from the next clock on and no strobe is issued. Both counters are cleared, so the first falling edge after enabling comes exactly one half-period after the first enabled clock edge.
- R8: scl_rise and scl_fall are each one system clock wide and are never active together. Each one is asserted in exactly the cycle in which scl_o takes its new level, and scl_o changes level only together with one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration write value (fine code [2:0], coarse code [4:3]) |
| cfg_rdata | output | 8 | Configuration read-back, bits [7:5] zero |
| en | input | 1 | Enable; low parks SCL high and clears the dividers |
| scl_o | output | 1 | Generated SCL level |
| scl_rise | output | 1 | One-cycle strobe in the cycle SCL becomes high |
| scl_fall | output | 1 | One-cycle strobe in the cycle SCL becomes low |

## Verification
The hardest case to reach is a configuration write that lands partway through a running SCL period. In that case the holding register and the active factors differ for a while. The bench enables the block at a short period and waits for a falling strobe. A few clocks later it writes a longer setting. It then checks that the next falling strobe still comes one old period later and that the interval after it has the new length. A second directed case drops en while SCL is low. It checks that SCL returns high without a rising strobe and that the half-period restarts from zero.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int CFG_W           = 8;
    localparam int FINE_CODE_W     = 3;
    localparam int COARSE_CODE_W   = 2;
    localparam int RSVD_W          = CFG_W - FINE_CODE_W - COARSE_CODE_W;
    localparam int FINE_MAX        = 8;
    localparam int COARSE_HALF_MAX = 512;
    localparam int FCNT_W          = $clog2(FINE_MAX);
    localparam int CCNT_W          = $clog2(COARSE_HALF_MAX);

    typedef struct packed {
        logic [RSVD_W-1:0]        rsvd;
        logic [COARSE_CODE_W-1:0] coarse;
        logic [FINE_CODE_W-1:0]   fine;
    } scl_cfg_t;

    // Terminal count of the fine counter: fine factor minus one.
    function automatic logic [FCNT_W-1:0] fine_last(input logic [FINE_CODE_W-1:0] code);
        logic [FCNT_W-1:0] r;
        if (!code[FINE_CODE_W-1]) begin
            r = FCNT_W'(1);
        end else begin
            case (code[1:0])
                2'b00:   r = FCNT_W'(2);
                2'b01:   r = FCNT_W'(3);
                2'b10:   r = FCNT_W'(4);
                default: r = FCNT_W'(7);
            endcase
        end
        return r;
    endfunction

    // Terminal count of the coarse counter: half the coarse factor minus one.
    function automatic logic [CCNT_W-1:0] coarse_last(input logic [COARSE_CODE_W-1:0] code);
        logic [CCNT_W-1:0] r;
        case (code)
            2'b00:   r = CCNT_W'(7);
            2'b01:   r = CCNT_W'(15);
            2'b10:   r = CCNT_W'(63);
            default: r = CCNT_W'(511);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             load_active,
    output scl_cfg_t         shadow,
    output scl_cfg_t         active
);

    scl_cfg_t wr_val;

    always_comb begin
        wr_val      = scl_cfg_t'(wdata);
        wr_val.rsvd = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (we) begin
            shadow <= wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (load_active) begin
            active <= shadow;
        end
    end

    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (rst)
        shadow.rsvd == '0);

    assert_active_held_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(load_active) |-> $stable(active));

endmodule

// File: rtl/scl_fine_tick.sv
module scl_fine_tick
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FCNT_W-1:0] last,
    output logic              tick
);

    logic [FCNT_W-1:0] fcnt;

    assign tick = en && (fcnt == last);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fcnt <= '0;
        end else if (fcnt == last) begin
            fcnt <= '0;
        end else begin
            fcnt <= fcnt + 1'b1;
        end
    end

    assert_fine_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        fcnt <= last);

    assert_fine_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> fcnt == '0);

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [CCNT_W-1:0] last,
    output logic              load_cfg,
    output logic              scl_o,
    output logic              rise,
    output logic              fall
);

    logic [CCNT_W-1:0] ccnt;
    logic              half_done;

    assign half_done = tick && (ccnt == last);
    assign load_cfg  = !en || (half_done && scl_o);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ccnt <= '0;
        end else if (tick) begin
            ccnt <= (ccnt == last) ? '0 : ccnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            scl_o <= 1'b1;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise  <= half_done && !scl_o;
            fall  <= half_done && scl_o;
            if (half_done) begin
                scl_o <= !scl_o;
            end
        end
    end

    assert_coarse_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        ccnt <= last);

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> scl_o && !rise && !fall);

    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));

    assert_rise_level_R8: assert property (@(posedge clk) disable iff (rst)
        rise |-> scl_o && !$past(scl_o));

    assert_fall_level_R8: assert property (@(posedge clk) disable iff (rst)
        fall |-> !scl_o && $past(scl_o));

    assert_toggle_strobed_R8: assert property (@(posedge clk) disable iff (rst)
        (scl_o != $past(scl_o)) && $past(en) |-> rise || fall);

    assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             en,
    output logic             scl_o,
    output logic             scl_rise,
    output logic             scl_fall
);

    scl_cfg_t          shadow_cfg;
    scl_cfg_t          active_cfg;
    logic              load_cfg;
    logic              fine_tick;
    logic [FCNT_W-1:0] fine_end;
    logic [CCNT_W-1:0] coarse_end;

    assign fine_end   = fine_last(active_cfg.fine);
    assign coarse_end = coarse_last(active_cfg.coarse);
    assign cfg_rdata  = CFG_W'(shadow_cfg);

    scl_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .load_active (load_cfg),
        .shadow      (shadow_cfg),
        .active      (active_cfg)
    );

    scl_fine_tick u_fine (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .last (fine_end),
        .tick (fine_tick)
    );

    scl_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (fine_tick),
        .last     (coarse_end),
        .load_cfg (load_cfg),
        .scl_o    (scl_o),
        .rise     (scl_rise),
        .fall     (scl_fall)
    );

    assert_no_edge_at_reset_R1: assert property (@(posedge clk)
        rst |=> scl_o && !scl_rise && !scl_fall && cfg_rdata == '0);

endmodule

// File: tb/scl_prescaler_test.sv
module scl_prescaler_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       en;
    logic       scl_o;
    logic       scl_rise;
    logic       scl_fall;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    scl_prescaler uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .en        (en),
        .scl_o     (scl_o),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    // {written value, expected read-back, expected half-period}
    localparam int NVEC = 12;
    localparam logic [31:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 16'd16},
        {8'h03, 8'h03, 16'd16},
        {8'h04, 8'h04, 16'd24},
        {8'h05, 8'h05, 16'd32},
        {8'h06, 8'h06, 16'd40},
        {8'h07, 8'h07, 16'd64},
        {8'h0D, 8'h0D, 16'd64},
        {8'h15, 8'h15, 16'd256},
        {8'h12, 8'h12, 16'd128},
        {8'h18, 8'h18, 16'd1024},
        {8'h1F, 8'h1F, 16'd4096},
        {8'hE9, 8'h09, 16'd32}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising clock edges until the chosen strobe is seen at a falling edge.
    task automatic wait_strobe(input bit want_rise, output int n);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (want_rise ? scl_rise : scl_fall) return;
        end
        n = -1;
    endtask

    task automatic write_cfg_idle(input logic [7:0] v);
        en        = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; en = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);

        // R1 reset state
        check(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
        check(scl_o == 1'b1, "R1 scl", scl_o, 1);
        check(!scl_rise && !scl_fall, "R1 strobes", scl_rise + scl_fall, 0);
        en = 1'b1;
        wait_strobe(1'b0, n);
        check(n == 16, "R1 default half", n, 16);
        wait_strobe(1'b0, n);
        check(n == 32, "R1 default period", n, 32);

        // Table: R5 readback, R2 and R3 code decode, R4 half periods
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] wv, rb;
            int half;
            wv = VECS[v][31:24];
            rb = VECS[v][23:16];
            half = int'(VECS[v][15:0]);
            write_cfg_idle(wv);
            check(cfg_rdata == rb, "R5 readback", cfg_rdata, rb);
            en = 1'b1;
            wait_strobe(1'b0, n);
            check(n == half, "R2 R3 first fall", n, half);
            check(scl_o == 1'b0, "R8 level at fall", scl_o, 0);
            @(posedge clk); @(negedge clk);
            check(!scl_fall, "R8 fall width", scl_fall, 0);
            wait_strobe(1'b1, n);
            check(n == half - 1, "R4 low half", n, half - 1);
            check(scl_o == 1'b1 && !scl_fall, "R8 level at rise", scl_o, 1);
            wait_strobe(1'b0, n);
            check(n == half, "R4 high half", n, half);
        end

        // R6: mid-period change keeps the running period, new one from next fall
        write_cfg_idle(8'h00);
        en = 1'b1;
        wait_strobe(1'b0, n);
        repeat (5) @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h05;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == 8'h05, "R6 holding written", cfg_rdata, 5);
        wait_strobe(1'b0, n);
        check(n == 32 - 6, "R6 old period kept", n, 26);
        wait_strobe(1'b1, n);
        check(n == 32, "R6 new low half", n, 32);
        wait_strobe(1'b0, n);
        check(n == 32, "R6 new high half", n, 32);

        // R7: disable while SCL low
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(scl_o == 1'b0, "R7 low before disable", scl_o, 0);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(scl_o == 1'b1, "R7 parked high", scl_o, 1);
        check(!scl_rise && !scl_fall, "R7 no strobe on park", scl_rise + scl_fall, 0);
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (scl_rise || scl_fall || !scl_o) begin
                check(1'b0, "R7 idle quiet", scl_o, 1);
                break;
            end
        end
        en = 1'b1;
        wait_strobe(1'b0, n);
        check(n == 32, "R7 restart half", n, 32);

        // R1: reset while running
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check(cfg_rdata == 8'h00 && scl_o == 1'b1, "R1 reset mid-run", cfg_rdata, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule